// File: doc/BRIEF.md
# Radix-2 Single-Delay-Feedback Butterfly Stage

This block is one streaming stage of a pipelined decimation-in-frequency FFT. Complex samples arrive one per valid cycle, with the real and the imaginary part on separate buses, grouped in frames of `VLEN` samples. A sample that carries `in_first` is position 0 of a frame. For a frame x[0..VLEN-1] with H = VLEN/2, the stage emits the H sums x[n]+x[n+H] in order of n, followed by the H differences x[n]-x[n+H] in order of n.

Every result is arithmetically shifted right by `TRUNC` bits and then saturated to a signed `W_OUT`-bit range. There is no rounding and no wrap. The real and imaginary parts go through identical, independent arithmetic.

A single feedback memory of H complex words does all the reordering. During the first half of a frame it stores the incoming samples. During the second half it supplies x[n], and the difference is written back into the slot x[n] came from. Those stored differences leave during the first half of the next frame, while that frame's samples take their place. The stage therefore runs H valid samples plus one register behind its input. This figure, `sdf_pkg::sdf_latency(VLEN)` = VLEN/2 + 1, is published so that later stages can align their control.

The sequencing is a three-state machine, and every transition takes place on a valid sample that is the last of a half-frame:
- **FILL** (after reset or a re-sync): input is stored and nothing is emitted. FILL goes to SUM.
- **SUM**: sums are emitted and differences are written back. SUM goes to DRAIN.
- **DRAIN**: the previous differences are emitted while new input is stored. DRAIN goes to SUM.

A valid `in_first` that arrives when the stage is not at position 0 forces FILL at position 0.

Top module: `sdf_butterfly`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `out_first` are 0 and `out_re`/`out_im` are 0.
- R2: After reset, no output is produced for the first VLEN/2 valid samples (state FILL).
- R3: The valid sample at frame position H+n produces, on the next clock edge, `out_valid`=1 with the value sat((x[n]+x[H+n]) >>> TRUNC). `out_first`=1 exactly for n=0.
- R4: Once a frame has completed its second half, the valid sample at position n of the following frame produces, on the next edge, sat((x[n]-x[H+n]) >>> TRUNC) of the earlier frame, with `out_first`=0.
- R5: The real and imaginary parts are computed independently with the same rule. The value on one bus never affects the other.
- R6: The shift is arithmetic: negative odd results round toward minus infinity (for example -3 >>> 1 = -2).
- R7: Shifted results above 2^(W_OUT-1)-1 become 2^(W_OUT-1)-1, and results below -2^(W_OUT-1) become -2^(W_OUT-1).
- R8: A cycle with `in_valid`=0 produces `out_valid`=0 on the next edge and does not advance the frame position.
- R9: A valid sample with `in_first`=1 at a nonzero position restarts the frame at position 0 in FILL. Pending differences are dropped, and that sample produces no output.
- R10: The output lags the input by VLEN/2 valid samples plus one clock, as given by `sdf_latency`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample qualifier |
| in_first | input | 1 | Marks frame position 0 |
| in_re | input | W_IN | Real part, signed |
| in_im | input | W_IN | Imaginary part, signed |
| out_valid | output | 1 | Output sample qualifier |
| out_first | output | 1 | Marks the first sum of a frame |
| out_re | output | W_OUT | Real result, signed |
| out_im | output | W_OUT | Imaginary result, signed |

## Verification
Full-scale frames of all-maximum, all-minimum and alternating values drive both sums and differences past the output range. A design that wraps instead of saturating would show sign flips there. Small negative odd values expose a shift that truncates toward zero, which would be off by one. Idle gaps inside a frame catch a position counter that advances without a valid sample, which would misplace every later result. A mid-frame `in_first` catches a stage that keeps emitting stale differences after a re-sync.

// File: rtl/sdf_pkg.sv
package sdf_pkg;

    // Sequencing states of the butterfly stage
    typedef enum logic [1:0] {
        ST_FILL  = 2'd0,
        ST_SUM   = 2'd1,
        ST_DRAIN = 2'd2
    } sdf_state_e;

    // Input-to-output delay in valid samples plus the output register
    function automatic int sdf_latency(input int vlen);
        return vlen / 2 + 1;
    endfunction

endpackage

// File: rtl/sdf_ctrl.sv
module sdf_ctrl #(
    parameter int VLEN = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     in_first,
    output logic [$clog2(VLEN/2)-1:0] addr,
    output logic                     mem_we,
    output logic                     wr_diff,
    output logic                     fire,
    output logic                     is_sum,
    output logic                     first_c,
    output sdf_pkg::sdf_state_e      state
);
    import sdf_pkg::*;

    localparam int HALF = VLEN / 2;
    localparam int HW   = $clog2(HALF);

    sdf_state_e     st_q, st_d, st_eff;
    logic [HW-1:0]  idx_q, idx_d, idx;
    logic           resync, last;

    // Effective position of the current sample after any re-sync
    always_comb begin
        resync = in_first && !((idx_q == '0) && (st_q != ST_SUM));
        idx    = in_first ? '0 : idx_q;
        st_eff = resync ? ST_FILL : st_q;
        last   = (idx == HW'(HALF - 1));
    end

    // Next-state logic
    always_comb begin
        st_d  = st_q;
        idx_d = idx_q;
        if (in_valid) begin
            st_d  = st_eff;
            idx_d = last ? '0 : idx + 1'b1;
            unique case (st_eff)
                ST_FILL:  if (last) st_d = ST_SUM;
                ST_SUM:   if (last) st_d = ST_DRAIN;
                ST_DRAIN: if (last) st_d = ST_SUM;
                default:  st_d = ST_FILL;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_FILL;
            idx_q <= '0;
        end else begin
            st_q  <= st_d;
            idx_q <= idx_d;
        end
    end

    // Output decode
    always_comb begin
        addr    = idx;
        mem_we  = in_valid;
        wr_diff = 1'b0;
        fire    = 1'b0;
        is_sum  = 1'b0;
        first_c = 1'b0;
        unique case (st_eff)
            ST_FILL: begin
                fire = 1'b0;
            end
            ST_SUM: begin
                wr_diff = 1'b1;
                is_sum  = 1'b1;
                fire    = in_valid;
                first_c = in_valid && (idx == '0);
            end
            ST_DRAIN: begin
                fire = in_valid;
            end
            default: begin
                fire = 1'b0;
            end
        endcase
    end

    assign state = st_q;

endmodule

// File: rtl/sdf_delay_line.sv
module sdf_delay_line #(
    parameter int WIDTH = 26,
    parameter int DEPTH = 4
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] addr,
    input  logic [WIDTH-1:0]         wdata,
    output logic [WIDTH-1:0]         rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Read-before-write on the same slot: old word out, new word in
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/sdf_scale_clamp.sv
module sdf_scale_clamp #(
    parameter int WS    = 13,
    parameter int W_OUT = 10,
    parameter int TRUNC = 1
) (
    input  logic signed [WS-1:0]    val,
    output logic signed [W_OUT-1:0] res
);
    localparam logic signed [WS-1:0] HI = WS'((1 <<< (W_OUT - 1)) - 1);
    localparam logic signed [WS-1:0] LO = WS'(-(1 <<< (W_OUT - 1)));

    logic signed [WS-1:0] sh;

    assign sh = val >>> TRUNC;

    always_comb begin
        if (sh > HI)      res = HI[W_OUT-1:0];
        else if (sh < LO) res = LO[W_OUT-1:0];
        else              res = sh[W_OUT-1:0];
    end

endmodule

// File: rtl/sdf_butterfly.sv
module sdf_butterfly #(
    parameter int VLEN  = 8,
    parameter int W_IN  = 12,
    parameter int W_OUT = 10,
    parameter int TRUNC = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_first,
    input  logic signed [W_IN-1:0]  in_re,
    input  logic signed [W_IN-1:0]  in_im,
    output logic                    out_valid,
    output logic                    out_first,
    output logic signed [W_OUT-1:0] out_re,
    output logic signed [W_OUT-1:0] out_im
);
    import sdf_pkg::*;

    localparam int HALF = VLEN / 2;
    localparam int HW   = $clog2(HALF);
    localparam int WS   = W_IN + 1;
    localparam int MW   = 2 * WS;

    logic [HW-1:0]  addr;
    logic           mem_we, wr_diff, fire, is_sum, first_c;
    sdf_state_e     state;
    logic [MW-1:0]  rdata, wdata;

    logic signed [WS-1:0]    x_in  [2];
    logic signed [WS-1:0]    x_old [2];
    logic signed [WS-1:0]    s_v   [2];
    logic signed [WS-1:0]    d_v   [2];
    logic signed [WS-1:0]    pick  [2];
    logic signed [W_OUT-1:0] y     [2];

    sdf_ctrl #(.VLEN(VLEN)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(in_valid),
        .in_first(in_first),
        .addr    (addr),
        .mem_we  (mem_we),
        .wr_diff (wr_diff),
        .fire    (fire),
        .is_sum  (is_sum),
        .first_c (first_c),
        .state   (state)
    );

    sdf_delay_line #(.WIDTH(MW), .DEPTH(HALF)) u_dly (
        .clk  (clk),
        .we   (mem_we),
        .addr (addr),
        .wdata(wdata),
        .rdata(rdata)
    );

    assign x_in[0] = {in_re[W_IN-1], in_re};
    assign x_in[1] = {in_im[W_IN-1], in_im};

    // One identical lane per component (0 = real, 1 = imaginary)
    for (genvar c = 0; c < 2; c++) begin : g_lane
        assign x_old[c] = rdata[c*WS +: WS];
        assign s_v[c]   = x_old[c] + x_in[c];
        assign d_v[c]   = x_old[c] - x_in[c];
        assign pick[c]  = is_sum ? s_v[c] : x_old[c];
        assign wdata[c*WS +: WS] = wr_diff ? d_v[c] : x_in[c];

        sdf_scale_clamp #(.WS(WS), .W_OUT(W_OUT), .TRUNC(TRUNC)) u_sat (
            .val(pick[c]),
            .res(y[c])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_first <= 1'b0;
            out_re    <= '0;
            out_im    <= '0;
        end else begin
            out_valid <= fire;
            out_first <= first_c;
            if (fire) begin
                out_re <= y[0];
                out_im <= y[1];
            end
        end
    end

endmodule

// File: rtl/sdf_butterfly_checker.sv
module sdf_butterfly_checker (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                in_first,
    input logic                out_valid,
    input logic                out_first,
    input sdf_pkg::sdf_state_e state
);
    import sdf_pkg::*;

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |-> (!out_valid && !out_first));

    assert_fill_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_first && state == ST_FILL) |=> !out_valid);

    assert_first_is_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_first |-> out_valid);

    assert_first_not_repeated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_first |=> !out_first);

    assert_stall_no_output_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_resync_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_first && state == ST_SUM) |=> !out_valid);

endmodule

bind sdf_butterfly sdf_butterfly_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_first (in_first),
    .out_valid(out_valid),
    .out_first(out_first),
    .state    (state)
);

// File: tb/sdf_butterfly_test.sv
module sdf_butterfly_test;
    localparam int VLEN  = 8;
    localparam int W_IN  = 12;
    localparam int W_OUT = 10;
    localparam int TRUNC = 1;
    localparam int HALF  = VLEN / 2;
    localparam int OMAX  = (1 << (W_OUT - 1)) - 1;
    localparam int OMIN  = -(1 << (W_OUT - 1));
    localparam int IMAX  = (1 << (W_IN - 1)) - 1;
    localparam int IMIN  = -(1 << (W_IN - 1));

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_first = 1'b0;
    logic signed [W_IN-1:0]  in_re = '0;
    logic signed [W_IN-1:0]  in_im = '0;
    logic                    out_valid, out_first;
    logic signed [W_OUT-1:0] out_re, out_im;

    int checks = 0;
    int errors = 0;
    int pos = 0;
    bit have_prev = 1'b0;
    int cur_re [VLEN];
    int cur_im [VLEN];
    int pd_re  [HALF];
    int pd_im  [HALF];

    always #2 clk = ~clk;

    sdf_butterfly #(.VLEN(VLEN), .W_IN(W_IN), .W_OUT(W_OUT), .TRUNC(TRUNC)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
        .in_re(in_re), .in_im(in_im), .out_valid(out_valid), .out_first(out_first),
        .out_re(out_re), .out_im(out_im)
    );

    function automatic int sc(input int v);
        int s;
        s = v >>> TRUNC;
        if (s > OMAX) s = OMAX;
        if (s < OMIN) s = OMIN;
        return s;
    endfunction

    function automatic int rnd();
        return int'($urandom_range(0, (1 << W_IN) - 1)) - (1 << (W_IN - 1));
    endfunction

    task automatic check_out(input string req, input bit ev, input bit ef,
                             input int er, input int ei);
        checks++;
        if (out_valid !== ev || out_first !== ef ||
            (ev && (int'(out_re) != er || int'(out_im) != ei))) begin
            errors++;
            $display("FAIL %s: got v=%0b f=%0b re=%0d im=%0d, expected v=%0b f=%0b re=%0d im=%0d",
                     req, out_valid, out_first, out_re, out_im, ev, ef, er, ei);
        end
    endtask

    // Drive one valid sample at a falling edge, check one clock later
    task automatic drive(input int re, input int im, input bit first, input string req);
        bit ev = 1'b0;
        bit ef = 1'b0;
        int er = 0;
        int ei = 0;
        if (first) begin
            if (pos != 0) have_prev = 1'b0;
            pos = 0;
        end
        if (pos < HALF) begin
            if (have_prev) begin
                ev = 1'b1;
                er = sc(pd_re[pos]);
                ei = sc(pd_im[pos]);
            end
            cur_re[pos] = re;
            cur_im[pos] = im;
        end else begin
            ev = 1'b1;
            ef = (pos == HALF);
            er = sc(cur_re[pos-HALF] + re);
            ei = sc(cur_im[pos-HALF] + im);
            pd_re[pos-HALF] = cur_re[pos-HALF] - re;
            pd_im[pos-HALF] = cur_im[pos-HALF] - im;
            if (pos == VLEN - 1) have_prev = 1'b1;
        end
        pos = (pos + 1) % VLEN;
        in_valid = 1'b1;
        in_first = first;
        in_re = re[W_IN-1:0];
        in_im = im[W_IN-1:0];
        @(negedge clk);
        in_valid = 1'b0;
        in_first = 1'b0;
        check_out(req, ev, ef, er, ei);
    endtask

    task automatic idle(input int n, input string req);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            check_out(req, 1'b0, 1'b0, 0, 0);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_first !== 1'b0 || out_re !== '0 || out_im !== '0) begin
            errors++;
            $display("FAIL R1: got v=%0b f=%0b re=%0d im=%0d, expected all zero",
                     out_valid, out_first, out_re, out_im);
        end
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_first_frame();
        for (int j = 0; j < VLEN; j++)
            drive(rnd(), rnd(), j == 0, j < HALF ? "R2 fill" : "R3 R10 sums");
    endtask

    task automatic t_stream();
        for (int f = 0; f < 4; f++)
            for (int j = 0; j < VLEN; j++)
                drive(rnd(), rnd(), j == 0, "R4 stream");
    endtask

    task automatic t_parts();
        for (int f = 0; f < 2; f++)
            for (int j = 0; j < VLEN; j++)
                drive(IMAX - 37 * j, 0, j == 0, "R5 independent parts");
    endtask

    task automatic t_fullscale();
        for (int j = 0; j < VLEN; j++) drive(IMAX, IMIN, j == 0, "R7 saturate");
        for (int j = 0; j < VLEN; j++) drive(IMIN, IMAX, j == 0, "R7 saturate");
        for (int j = 0; j < VLEN; j++)
            drive(j < HALF ? IMAX : IMIN, j < HALF ? IMIN : IMAX, j == 0, "R7 saturate diff");
        for (int j = 0; j < VLEN; j++) drive(1, 1, j == 0, "R7 after saturation");
    endtask

    task automatic t_shift();
        for (int f = 0; f < 2; f++)
            for (int j = 0; j < VLEN; j++)
                drive(j < HALF ? -3 : 0, j < HALF ? -1 : 2, j == 0, "R6 arithmetic shift");
    endtask

    task automatic t_stall();
        for (int f = 0; f < 2; f++)
            for (int j = 0; j < VLEN; j++) begin
                drive(rnd(), rnd(), j == 0, "R8 stalled stream");
                idle(int'($urandom_range(0, 3)), "R8 idle");
            end
    endtask

    task automatic t_resync();
        for (int j = 0; j < HALF + 2; j++) drive(rnd(), rnd(), j == 0, "R9 partial frame");
        for (int f = 0; f < 2; f++)
            for (int j = 0; j < VLEN; j++)
                drive(rnd(), rnd(), j == 0, "R9 after resync");
        for (int j = 0; j < 2; j++) drive(rnd(), rnd(), j == 0, "R9 partial drain");
        for (int j = 0; j < VLEN; j++) drive(rnd(), rnd(), j == 0, "R9 resync in drain");
        for (int j = 0; j < HALF; j++) drive(0, 0, j == 0, "R9 flush");
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_first_frame();
        t_stream();
        t_parts();
        t_fullscale();
        t_shift();
        t_stall();
        t_resync();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule